// File: doc/BRIEF.md
# Dual Chip-Select Address Decoder

This block sits between an internal bus and a host-bus style external memory interface. For each accepted request it looks at the upper address bits and decides which of two active-low external chip selects to drive. It also reports which timing profile the bus cycle logic should apply, and whether the access hit a configured window at all. The chip-select mode field, two window fields and a per-chip-select timing enable arrive as plain static control inputs. They are sampled when a request is accepted.

Each window field names a fixed, aligned region: the top `WIN_W` address bits must equal the field. A field of zero disables that window. In the two dual-select modes the two fields work together in one of two ways. If exactly one field is set, that window is split in half by the bit just below the field, and each half gets its own chip select. If both fields are set, each chip select owns one whole window. Any other mode drives a single device on chip select 0.

Requests use a valid/ready handshake. A request transfers on a cycle where `req_valid` and `req_ready` are both high. `req_ready` stays low for as long as a chip select is held. The external cycle logic releases the chip select by pulsing `cyc_done`. A request that matches no window is consumed at once: it raises a one-cycle `miss_err` and does not drop `req_ready`.

Top module: `dcs_decoder`

## Requirements
- R1: After reset, `cs_n` is 2'b11, and `hit`, `miss_err` and `prof_sel` are 0, while `req_ready` is 1.
- R2: A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. On a hit, `hit` and the chip select appear one cycle after acceptance. `req_ready` stays low while `hit` is high, and requests presented during that time are not taken.
- R3: When `cs_mode` is 0 or 1, an address whose top 4 bits (`req_addr_hi[4:1]`) equal either nonzero window field asserts chip select 0 only (`cs_n` = 2'b10; bit 0 is chip select 0 and bit 1 is chip select 1, both active low).
- R4: When `cs_mode` is 2 or 3 and only `periph_win` is nonzero, a peripheral-window match asserts chip select 0 if `req_addr_hi[0]` is 0 (`cs_n` = 2'b10), or chip select 1 if it is 1 (`cs_n` = 2'b01).
- R5: When `cs_mode` is 2 or 3 and only `mem_win` is nonzero, a memory-window match is split on `req_addr_hi[0]` in the same way as R4.
- R6: When `cs_mode` is 2 or 3 and both fields are nonzero, a peripheral-window match asserts chip select 0 and a memory-window match asserts chip select 1, whatever `req_addr_hi[0]` is. If both windows match (equal fields), chip select 0 wins.
- R7: A request matching no enabled window asserts no chip select. It raises `miss_err` for exactly the one cycle after acceptance, and `req_ready` stays 1.
- R8: While `hit` is high, exactly one chip select is low, and `cs_n` and `prof_sel` hold their values until `cyc_done` is sampled high. They stay put even if the configuration inputs change. On the cycle after that, `cs_n` is 2'b11, `hit` is 0 and `req_ready` is 1.
- R9: `prof_sel` is 1 (the chip select 1 timing profile) only when `split_timing` was 1 at acceptance and chip select 1 was chosen. Otherwise it is 0 (the chip select 0 profile, shared by both selects).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_mode | input | 2 | Chip-select mode; 2 or 3 selects dual chip select |
| periph_win | input | 4 | Peripheral window field, 0 = disabled |
| mem_win | input | 4 | Memory window field, 0 = disabled |
| split_timing | input | 1 | 1 = each chip select has its own timing profile |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Decoder can accept a request |
| req_addr_hi | input | 5 | Upper request address bits: [4:1] window, [0] split bit |
| cyc_done | input | 1 | External bus cycle finished; releases the chip select |
| cs_n | output | 2 | Active-low chip selects, bit 0 = select 0 |
| prof_sel | output | 1 | Timing profile index for the current cycle |
| hit | output | 1 | A chip select is being held |
| miss_err | output | 1 | One-cycle pulse for an unmatched request |

## Verification
The hardest case to reach is a request that is held and then disturbed. While a chip select is waiting for `cyc_done`, a second request sits on the handshake and the configuration inputs change under it. The stimulus keeps `req_valid` high with a new address across several held cycles, rewrites the mode and window fields, and only then pulses `cyc_done`. It then checks that the held select never moved and that the waiting request is taken on the first ready cycle. The two-window case with equal fields is also driven, to pin down the priority of chip select 0.

// File: rtl/dcs_pkg.sv
package dcs_pkg;
  localparam int N_CS = 2;

  typedef enum logic [2:0] {
    MAP_OFF,
    MAP_SINGLE,
    MAP_SPLIT_PERIPH,
    MAP_SPLIT_MEM,
    MAP_TWO_WINDOWS
  } map_kind_t;

  typedef struct packed {
    logic            hit;
    logic [N_CS-1:0] cs_oh;
    logic            prof;
  } decode_t;

  typedef enum logic {
    ST_IDLE,
    ST_HOLD
  } dcs_state_t;
endpackage

// File: rtl/dcs_window_match.sv
module dcs_window_match #(
  parameter int WIN_W = 4
) (
  input  logic [WIN_W-1:0] win_field,
  input  logic [WIN_W-1:0] addr_top,
  output logic             enabled,
  output logic             match
);
  always_comb begin
    enabled = |win_field;
    match   = enabled && (addr_top == win_field);
  end
endmodule

// File: rtl/dcs_map_classify.sv
module dcs_map_classify
  import dcs_pkg::*;
(
  input  logic [1:0] cs_mode,
  input  logic       periph_en,
  input  logic       mem_en,
  output map_kind_t  kind
);
  logic dual;

  always_comb begin
    dual = (cs_mode == 2'd2) || (cs_mode == 2'd3);
    if (!dual)
      kind = MAP_SINGLE;
    else if (periph_en && mem_en)
      kind = MAP_TWO_WINDOWS;
    else if (periph_en)
      kind = MAP_SPLIT_PERIPH;
    else if (mem_en)
      kind = MAP_SPLIT_MEM;
    else
      kind = MAP_OFF;
  end
endmodule

// File: rtl/dcs_route.sv
module dcs_route
  import dcs_pkg::*;
(
  input  map_kind_t kind,
  input  logic      periph_match,
  input  logic      mem_match,
  input  logic      split_bit,
  input  logic      split_timing,
  output decode_t   dec
);
  logic [N_CS-1:0] half_oh;

  always_comb begin
    half_oh = split_bit ? 2'b10 : 2'b01;
    dec     = '0;
    unique case (kind)
      MAP_SINGLE: begin
        if (periph_match || mem_match) begin
          dec.hit   = 1'b1;
          dec.cs_oh = 2'b01;
        end
      end
      MAP_SPLIT_PERIPH: begin
        if (periph_match) begin
          dec.hit   = 1'b1;
          dec.cs_oh = half_oh;
        end
      end
      MAP_SPLIT_MEM: begin
        if (mem_match) begin
          dec.hit   = 1'b1;
          dec.cs_oh = half_oh;
        end
      end
      MAP_TWO_WINDOWS: begin
        if (periph_match) begin
          dec.hit   = 1'b1;
          dec.cs_oh = 2'b01;
        end else if (mem_match) begin
          dec.hit   = 1'b1;
          dec.cs_oh = 2'b10;
        end
      end
      default: dec = '0;
    endcase
    dec.prof = split_timing && dec.cs_oh[1];
  end
endmodule

// File: rtl/dcs_decoder.sv
module dcs_decoder
  import dcs_pkg::*;
#(
  parameter int WIN_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       cs_mode,
  input  logic [WIN_W-1:0] periph_win,
  input  logic [WIN_W-1:0] mem_win,
  input  logic             split_timing,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [WIN_W:0]   req_addr_hi,
  input  logic             cyc_done,
  output logic [N_CS-1:0]  cs_n,
  output logic             prof_sel,
  output logic             hit,
  output logic             miss_err
);
  localparam int N_WIN = 2;

  logic [N_WIN-1:0][WIN_W-1:0] win_fields;
  logic [N_WIN-1:0]            win_en;
  logic [N_WIN-1:0]            win_match;
  map_kind_t                   kind;
  decode_t                     dec;

  dcs_state_t      state_q;
  logic [N_CS-1:0] cs_n_q;
  logic            prof_q;
  logic            miss_q;

  assign win_fields = {mem_win, periph_win};

  for (genvar w = 0; w < N_WIN; w++) begin : g_win
    dcs_window_match #(.WIN_W(WIN_W)) u_match (
      .win_field (win_fields[w]),
      .addr_top  (req_addr_hi[WIN_W:1]),
      .enabled   (win_en[w]),
      .match     (win_match[w])
    );
  end

  dcs_map_classify u_classify (
    .cs_mode   (cs_mode),
    .periph_en (win_en[0]),
    .mem_en    (win_en[1]),
    .kind      (kind)
  );

  dcs_route u_route (
    .kind         (kind),
    .periph_match (win_match[0]),
    .mem_match    (win_match[1]),
    .split_bit    (req_addr_hi[0]),
    .split_timing (split_timing),
    .dec          (dec)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cs_n_q  <= '1;
      prof_q  <= 1'b0;
      miss_q  <= 1'b0;
    end else begin
      miss_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (req_valid) begin
            if (dec.hit) begin
              state_q <= ST_HOLD;
              cs_n_q  <= ~dec.cs_oh;
              prof_q  <= dec.prof;
            end else begin
              miss_q <= 1'b1;
            end
          end
        end
        ST_HOLD: begin
          if (cyc_done) begin
            state_q <= ST_IDLE;
            cs_n_q  <= '1;
            prof_q  <= 1'b0;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready = (state_q == ST_IDLE);
  assign hit       = (state_q == ST_HOLD);
  assign cs_n      = cs_n_q;
  assign prof_sel  = prof_q;
  assign miss_err  = miss_q;
endmodule

// File: rtl/dcs_decoder_chk.sv
module dcs_decoder_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] cs_n,
  input logic       hit,
  input logic       miss_err,
  input logic       req_ready,
  input logic       prof_sel,
  input logic       cyc_done
);
  assert_one_select_R8: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> ($countones(~cs_n) == 1));

  assert_idle_released_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |-> (cs_n == 2'b11));

  assert_held_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !cyc_done) |=> (hit && $stable(cs_n) && $stable(prof_sel)));

  assert_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && cyc_done) |=> (!hit && req_ready && cs_n == 2'b11));

  assert_backpressure_R2: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> !req_ready);

  assert_miss_no_select_R7: assert property (@(posedge clk) disable iff (!rst_n)
    miss_err |-> (cs_n == 2'b11 && !hit && req_ready));

  assert_profile_cs1_R9: assert property (@(posedge clk) disable iff (!rst_n)
    prof_sel |-> (hit && !cs_n[1]));
endmodule

bind dcs_decoder dcs_decoder_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cs_n      (cs_n),
  .hit       (hit),
  .miss_err  (miss_err),
  .req_ready (req_ready),
  .prof_sel  (prof_sel),
  .cyc_done  (cyc_done)
);

// File: tb/dcs_decoder_test.sv
`timescale 1ns/1ps
module dcs_decoder_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] cs_mode = '0;
  logic [3:0] periph_win = '0;
  logic [3:0] mem_win = '0;
  logic       split_timing = 1'b0;
  logic       req_valid = 1'b0;
  logic       req_ready;
  logic [4:0] req_addr_hi = '0;
  logic       cyc_done = 1'b0;
  logic [1:0] cs_n;
  logic       prof_sel;
  logic       hit;
  logic       miss_err;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  dcs_decoder uut (
    .clk(clk), .rst_n(rst_n), .cs_mode(cs_mode), .periph_win(periph_win),
    .mem_win(mem_win), .split_timing(split_timing), .req_valid(req_valid),
    .req_ready(req_ready), .req_addr_hi(req_addr_hi), .cyc_done(cyc_done),
    .cs_n(cs_n), .prof_sel(prof_sel), .hit(hit), .miss_err(miss_err)
  );

  // {mode[2], periph[4], mem[4], split[1], addr_hi[5], exp_cs_n[2], exp_prof[1], exp_miss[1], req_no[4]}
  localparam int NV = 14;
  localparam logic [23:0] VEC [NV] = '{
    {2'd0, 4'h3, 4'h0, 1'b0, {4'h3, 1'b1}, 2'b10, 1'b0, 1'b0, 4'd3},  // R3
    {2'd1, 4'h0, 4'h5, 1'b0, {4'h5, 1'b0}, 2'b10, 1'b0, 1'b0, 4'd3},  // R3
    {2'd0, 4'h3, 4'h5, 1'b0, {4'h7, 1'b0}, 2'b11, 1'b0, 1'b1, 4'd7},  // R7
    {2'd2, 4'h3, 4'h0, 1'b0, {4'h3, 1'b0}, 2'b10, 1'b0, 1'b0, 4'd4},  // R4
    {2'd2, 4'h3, 4'h0, 1'b0, {4'h3, 1'b1}, 2'b01, 1'b0, 1'b0, 4'd4},  // R4
    {2'd3, 4'h3, 4'h0, 1'b1, {4'h3, 1'b1}, 2'b01, 1'b1, 1'b0, 4'd9},  // R9
    {2'd2, 4'h0, 4'h9, 1'b1, {4'h9, 1'b0}, 2'b10, 1'b0, 1'b0, 4'd5},  // R5
    {2'd3, 4'h0, 4'h9, 1'b0, {4'h9, 1'b1}, 2'b01, 1'b0, 1'b0, 4'd5},  // R5
    {2'd2, 4'h3, 4'h9, 1'b1, {4'h3, 1'b1}, 2'b10, 1'b0, 1'b0, 4'd6},  // R6
    {2'd2, 4'h3, 4'h9, 1'b1, {4'h9, 1'b0}, 2'b01, 1'b1, 1'b0, 4'd6},  // R6
    {2'd3, 4'h4, 4'h4, 1'b0, {4'h4, 1'b1}, 2'b10, 1'b0, 1'b0, 4'd6},  // R6
    {2'd2, 4'h0, 4'h0, 1'b0, {4'h0, 1'b0}, 2'b11, 1'b0, 1'b1, 4'd7},  // R7
    {2'd1, 4'h3, 4'h0, 1'b1, {4'h3, 1'b1}, 2'b10, 1'b0, 1'b0, 4'd9},  // R9
    {2'd2, 4'h3, 4'h0, 1'b0, {4'h5, 1'b0}, 2'b11, 1'b0, 1'b1, 4'd7}   // R7
  };

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  initial begin : main
    repeat (3) @(negedge clk);
    chk("R1", "cs_n", 32'(cs_n), 32'h3);
    chk("R1", "hit", 32'(hit), 32'h0);
    chk("R1", "miss_err", 32'(miss_err), 32'h0);
    chk("R1", "req_ready", 32'(req_ready), 32'h1);
    chk("R1", "prof_sel", 32'(prof_sel), 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      string tag;
      logic [1:0] e_cs;
      logic e_prof, e_miss;
      tag = $sformatf("R%0d vec%0d", VEC[i][3:0], i);
      {cs_mode, periph_win, mem_win, split_timing, req_addr_hi} = VEC[i][23:8];
      e_cs = VEC[i][7:6];
      e_prof = VEC[i][5];
      e_miss = VEC[i][4];
      req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      chk(tag, "cs_n", 32'(cs_n), 32'(e_cs));
      chk(tag, "prof_sel", 32'(prof_sel), 32'(e_prof));
      chk(tag, "miss_err", 32'(miss_err), 32'(e_miss));
      chk(tag, "hit", 32'(hit), 32'(!e_miss));
      chk(tag, "req_ready", 32'(req_ready), 32'(e_miss));
      @(negedge clk);
      if (e_miss) begin
        chk("R7 pulse", "miss_err", 32'(miss_err), 32'h0);
      end else begin
        chk("R8 hold", "cs_n", 32'(cs_n), 32'(e_cs));
        cyc_done = 1'b1;
        @(negedge clk);
        cyc_done = 1'b0;
        chk("R8 release", "cs_n", 32'(cs_n), 32'h3);
        chk("R8 release", "req_ready", 32'(req_ready), 32'h1);
      end
    end

    // R2 / R8: back-pressure and config churn during a held select
    cs_mode = 2'd2; periph_win = 4'h3; mem_win = 4'h9; split_timing = 1'b1;
    req_addr_hi = {4'h9, 1'b0};
    req_valid = 1'b1;
    @(negedge clk);
    req_addr_hi = {4'h3, 1'b0};  // waiting request, should map to select 0
    chk("R2 accept", "cs_n", 32'(cs_n), 32'h1);
    chk("R9 held", "prof_sel", 32'(prof_sel), 32'h1);
    for (int k = 0; k < 3; k++) begin
      cs_mode = 2'(k);
      mem_win = 4'(k);
      @(negedge clk);
      chk("R2 backpressure", "req_ready", 32'(req_ready), 32'h0);
      chk("R8 stable", "cs_n", 32'(cs_n), 32'h1);
      chk("R8 stable", "prof_sel", 32'(prof_sel), 32'h1);
    end
    cs_mode = 2'd2; mem_win = 4'h9;
    cyc_done = 1'b1;
    @(negedge clk);
    cyc_done = 1'b0;
    chk("R8 release", "hit", 32'(hit), 32'h0);
    chk("R8 release", "cs_n", 32'(cs_n), 32'h3);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R2 queued accept", "cs_n", 32'(cs_n), 32'h2);
    chk("R2 queued accept", "prof_sel", 32'(prof_sel), 32'h0);
    cyc_done = 1'b1;
    @(negedge clk);
    cyc_done = 1'b0;

    // R7: back-to-back misses keep ready high
    cs_mode = 2'd3; periph_win = 4'h0; mem_win = 4'h0;
    req_addr_hi = {4'h0, 1'b1};
    req_valid = 1'b1;
    @(negedge clk);
    chk("R7 miss1", "req_ready", 32'(req_ready), 32'h1);
    chk("R7 miss1", "miss_err", 32'(miss_err), 32'h1);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R7 miss2", "miss_err", 32'(miss_err), 32'h1);
    chk("R7 miss2", "cs_n", 32'(cs_n), 32'h3);
    @(negedge clk);
    chk("R7 end", "miss_err", 32'(miss_err), 32'h0);

    // R1: reset in the middle of a held select
    cs_mode = 2'd0; periph_win = 4'h3;
    req_addr_hi = {4'h3, 1'b0};
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    rst_n = 1'b0;
    #1;
    chk("R1 async", "cs_n", 32'(cs_n), 32'h3);
    chk("R1 async", "req_ready", 32'(req_ready), 32'h1);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    done = 1'b1;
  end

  initial begin : watchdog
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog run did not complete");
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule